// File: doc/BRIEF.md
# SMM Memory Window Access Steering

This block holds the control word for the system-management memory window and decides, for each host access that lands inside that window, whether the access is served by DRAM or forwarded to the PCI side. Software reaches the 32-bit control word through a simple read/write port with byte enables. The routing decision is combinational on the registered control bits and the per-access inputs: an in-window flag, a code-fetch flag and the SMM-mode pin.

Four control bits matter:
- an enable bit (31);
- an open bit (26), which sends every window access to memory;
- a closed bit (25), which admits only code fetches made in SMM mode;
- a lock bit (24).

The lock bit can only be set. Once it is set, hardware keeps the open bit at zero and ignores further writes to it. Only reset clears the lock.

Top module: `smm_route_ctl`

## Requirements
- R1: After reset the control word reads 0x0000_0000, with enable, open, closed and lock all clear.
- R2: A write with `cfg_be[3]` high updates bits 31, 26 and 25 from `cfg_wdata` at the next rising clock edge. A write with `cfg_be[3]` low leaves the control word unchanged.
- R3: Bits 30:27 and 23:0 always read as 0, whatever is written to them.
- R4: While enable (bit 31) is clear, every in-window access is routed to PCI.
- R5: With enable and open (bit 26) set, every in-window access goes to memory, for code and data alike and whatever the SMM pin says.
- R6: With enable and closed (bit 25) set and open clear, an in-window access goes to memory only when it is a code fetch and `smm_active` is high. Data accesses go to PCI.
- R7: With enable set and both open and closed clear, an in-window access goes to memory exactly when `smm_active` is high.
- R8: When open and closed are both set, open takes precedence.
- R9: Lock (bit 24) is set by writing 1 with `cfg_be[3]` high. Once set it stays set, writes of 0 are ignored, and only reset clears it.
- R10: While lock is set, or in the same write that sets it, the open bit becomes 0 and later writes to it have no effect.
- R11: When `acc_in_win` is high, exactly one of `route_mem` and `route_pci` is high. When it is low, both are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control word write strobe |
| cfg_be | input | 4 | Byte enables for the write; bit 3 covers bits 31:24 |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current control word |
| acc_in_win | input | 1 | Host access falls in the SMM window |
| acc_is_code | input | 1 | Access is a code fetch (1) or a data access (0) |
| smm_active | input | 1 | Host is in system-management mode |
| route_mem | output | 1 | Send the access to DRAM |
| route_pci | output | 1 | Send the access to PCI |

## Verification
The assertions assume that the control inputs hold a known 0 or 1 on every sampled edge after reset, and that the per-access flags are meaningful only together with `acc_in_win`. The stimulus drives every input to a defined level on the falling edge, including while `acc_in_win` is low. It walks all eight combinations of window, code and SMM flags in each of the routing modes, and it places lock writes both alongside an attempt to set open and after it.

// File: rtl/smm_route_ctl.sv
module smm_route_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        acc_in_win,
  input  logic        acc_is_code,
  input  logic        smm_active,
  output logic        route_mem,
  output logic        route_pci
);
  localparam int EnBit    = 31;
  localparam int OpenBit  = 26;
  localparam int ShutBit  = 25;
  localparam int LockBit  = 24;

  logic en_q, open_q, shut_q, lock_q;
  logic top_wr, lock_nx, mem_ok;

  assign top_wr  = cfg_we & cfg_be[3];
  assign lock_nx = lock_q | (top_wr & cfg_wdata[LockBit]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      open_q <= 1'b0;
      shut_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      lock_q <= lock_nx;
      if (top_wr) begin
        en_q   <= cfg_wdata[EnBit];
        shut_q <= cfg_wdata[ShutBit];
      end
      if (lock_nx)
        open_q <= 1'b0;
      else if (top_wr)
        open_q <= cfg_wdata[OpenBit];
    end
  end

  always_comb begin
    cfg_rdata          = '0;
    cfg_rdata[EnBit]   = en_q;
    cfg_rdata[OpenBit] = open_q;
    cfg_rdata[ShutBit] = shut_q;
    cfg_rdata[LockBit] = lock_q;
  end

  always_comb begin
    if (!en_q)        mem_ok = 1'b0;
    else if (open_q)  mem_ok = 1'b1;
    else if (shut_q)  mem_ok = acc_is_code & smm_active;
    else              mem_ok = smm_active;
  end

  assign route_mem = acc_in_win & mem_ok;
  assign route_pci = acc_in_win & ~mem_ok;
endmodule

module smm_route_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_rdata,
  input logic        acc_in_win,
  input logic        route_mem,
  input logic        route_pci
);
  // R11
  one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_in_win |-> $countones({route_mem, route_pci}) == 1);
  // R11
  no_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_in_win |-> !route_mem && !route_pci);
  // R4
  off_to_pci_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_in_win && !cfg_rdata[31]) |-> route_pci);
  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[24] |=> cfg_rdata[24]);
  // R10
  lock_shuts_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[24] |-> !cfg_rdata[26]);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_be[3]) |=> $stable(cfg_rdata));
  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[30:27] == 4'h0 && cfg_rdata[23:0] == 24'h0);
endmodule

bind smm_route_ctl smm_route_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_be(cfg_be),
  .cfg_rdata(cfg_rdata), .acc_in_win(acc_in_win),
  .route_mem(route_mem), .route_pci(route_pci));

// File: tb/smm_route_ctl_test.sv
`timescale 1ns/1ps
module smm_route_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_be = 4'h0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic acc_in_win = 1'b0, acc_is_code = 1'b0, smm_active = 1'b0;
  logic route_mem, route_pci;

  int checks = 0;
  int fails = 0;
  bit m_en = 0, m_open = 0, m_shut = 0, m_lock = 0;

  always #2.5 clk = ~clk;

  smm_route_ctl uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input logic [3:0] be, input logic [31:0] wd,
                     input bit win, input bit code, input bit smm);
    logic [31:0] exp_rd;
    bit to_mem;
    string rt;
    @(negedge clk);
    cfg_we = we; cfg_be = be; cfg_wdata = wd;
    acc_in_win = win; acc_is_code = code; smm_active = smm;
    #1;
    exp_rd = {m_en, 4'b0, m_open, m_shut, m_lock, 24'h0};
    chk(m_lock ? "R10" : "R2", cfg_rdata, exp_rd);
    if (!m_en) begin to_mem = 0; rt = "R4"; end
    else if (m_open) begin to_mem = 1; rt = m_shut ? "R8" : "R5"; end
    else if (m_shut) begin to_mem = code && smm; rt = "R6"; end
    else begin to_mem = smm; rt = "R7"; end
    if (!win) rt = "R11";
    chk(rt, {30'h0, route_mem, route_pci}, {30'h0, win && to_mem, win && !to_mem});
    @(posedge clk);
    if (we && be[3]) begin
      bit nl;
      nl = m_lock || wd[24];
      m_en = wd[31];
      m_shut = wd[25];
      m_open = nl ? 1'b0 : wd[26];
      m_lock = nl;
    end else if (m_lock) m_open = 0;
  endtask

  task automatic sweep();
    for (int i = 0; i < 8; i++) cyc(0, 4'h0, 32'h0, i[2], i[1], i[0]);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1 chk("R1", cfg_rdata, 32'h0);
    rst_n = 1'b1;
    sweep();                                    // R4
    cyc(1, 4'b0111, 32'hFFFF_FFFF, 1, 1, 1);    // R2 no top byte
    sweep();
    cyc(1, 4'hF, 32'hF8FF_FFFF, 1, 0, 1);       // R3 reserved, enable only
    sweep();                                    // R7
    cyc(1, 4'h8, 32'h8200_0000, 0, 0, 0);
    sweep();                                    // R6
    cyc(1, 4'h8, 32'h8400_0000, 0, 0, 0);
    sweep();                                    // R5
    cyc(1, 4'h8, 32'h8600_0000, 0, 0, 0);
    sweep();                                    // R8
    cyc(1, 4'h8, 32'h0600_0000, 0, 0, 0);
    sweep();                                    // R4
    cyc(1, 4'h8, 32'h8500_0000, 1, 0, 0);       // R10 lock with open
    sweep();
    cyc(1, 4'h8, 32'h8400_0000, 1, 0, 1);       // R9 lock write 0
    sweep();
    cyc(1, 4'h8, 32'h8600_0000, 1, 1, 1);       // R10 open blocked
    sweep();
    cyc(0, 4'h0, 32'h0, 0, 0, 0);
    finish_run();
  end
endmodule